// File: doc/BRIEF.md
# Capability Handle Seal and Check Engine

This block moves capability handles between the form they take inside a handle register, a segment name plus a port bit vector, and the form they take once stored in memory: a scrambled name, the port, and a validation tag. The name is scrambled under the key of the running process. The tag is computed under the key of the target segment, over the scrambled name and the port together. A forged port therefore fails the check, and so does a handle copied out of another process's memory.

One operation is in flight at a time. It is started with a one-cycle `start` pulse.
- **Load** unscrambles the name, fetches the segment key and recomputes the tag. It returns the plaintext name and port only if the recomputed tag matches the one supplied.
- **Store** seals a plaintext handle.
- **Reduce** clears port bits with a mask, then seals.
- **Transcode** clears port bits, then seals under a second process key. It is refused unless both supplied ports carry the owner bit.

Segment keys come from an external lookup port that answers with an acknowledge, a key, and a missing-segment flag. The cipher is a small invertible keyed permutation. It stands in for a real cipher.

Top module: `hs_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `lk_req`, `status` and all three result fields are zero.
- R2: Cipher E_k(x) on 16 bits uses four rounds, i = 0..3. Each round forms rk = rotl(k, 4i) XOR low16(0x9E37*(i+1)), then sets x = rotl((x + rk) mod 2^16, 5) XOR rk. Store (op 1) returns the triple. Its name field is S* = E_pk(S). Its port field is T. Its tag is T* = E_ks(E_ks(S*) XOR zero-extended T). Status is 0 (ok).
- R3: Load (op 0) takes S* from `in_name` and recovers S by inverting E under `proc_key`. It presents S on `lk_name`. When the recomputed tag equals `in_tag`, it returns status 0, name S, the port unchanged and tag 0.
- R4: On a load whose recomputed tag differs from `in_tag`, status is 2 (protection violation) and all result fields are zero.
- R5: When the lookup answers with `lk_miss` set, status is 1 (addressing violation) and all result fields are zero, for any operation.
- R6: Reduce (op 2) seals exactly as a store does, but with the port replaced by `in_port AND mask`.
- R7: Transcode (op 3) seals with the port `in_port AND mask`, scrambling the name under `alt_key`. If bit 7 (owner) of `in_port` or of `alt_port` is clear, status is 2, all result fields are zero, and `lk_req` is never raised.
- R8: `done` is a one-cycle pulse. With the lookup acknowledged W cycles after `lk_req` rises, `done` is seen in these cycles after the cycle in which `start` is driven: 5+W for a completed seal or check, 3+W for a missing segment, and 2 for a refused transcode. `lk_req` and `lk_name` hold steady until acknowledged.
- R9: A `start` pulse while `busy` is high is ignored. The running operation's result is unchanged and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 0 load, 1 store, 2 reduce, 3 transcode |
| in_name | input | 16 | Plain name (seal ops) or scrambled name (load) |
| in_port | input | 8 | Port bit vector, bit 7 = owner |
| in_tag | input | 16 | Validation tag to check (load) |
| mask | input | 8 | Port mask (reduce, transcode) |
| proc_key | input | 16 | Running process key |
| alt_key | input | 16 | Destination process key (transcode) |
| alt_port | input | 8 | Port of the destination descriptor handle (transcode) |
| lk_req | output | 1 | Segment key lookup request |
| lk_name | output | 16 | Plain segment name being looked up |
| lk_ack | input | 1 | Lookup answered |
| lk_miss | input | 1 | No such segment |
| lk_key | input | 16 | Segment key |
| busy | output | 1 | Operation in flight |
| done | output | 1 | Result valid pulse |
| status | output | 2 | 0 ok, 1 addressing violation, 2 protection violation |
| out_name | output | 16 | Result name field |
| out_port | output | 8 | Result port field |
| out_tag | output | 16 | Result tag field (0 on load) |

## Verification
Results fall due at fixed distances from the `start` cycle:
- a refused transcode 2 cycles later;
- a missing segment 3+W cycles later;
- a full seal or check 5+W cycles later, where W is the lookup wait the bench's key responder inserts.

Every vector carries its own W, and the bench counts the falling clock edges from the one that drives `start` to the one where `done` is first seen. It compares that count with the expected latency, so a result that arrives early or late fails even when its values are right. Outputs are sampled only at falling edges. The bench also records the lookup name and the number of request cycles.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_REDUCE = 2'd2,
    OP_XCODE  = 2'd3
  } hs_op_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_ADDR = 2'd1,
    ST_PROT = 2'd2
  } hs_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_NAME,
    S_LOOK,
    S_TAG1,
    S_TAG2
  } hs_state_e;
endpackage

// File: rtl/hs_cipher.sv
// Keyed invertible permutation: add round key, rotate, xor round key.
module hs_cipher #(
  parameter int BW     = 16,
  parameter int ROUNDS = 4,
  parameter int ROT    = 5,
  parameter int KROT   = 4,
  parameter int RC     = 32'h9E37
) (
  input  logic [BW-1:0] din,
  input  logic [BW-1:0] key,
  input  logic          decrypt,
  output logic [BW-1:0] dout
);
  localparam int RS = ROT % BW;

  function automatic logic [BW-1:0] rotl(input logic [BW-1:0] x, input int n);
    if (n == 0) return x;
    return (x << n) | (x >> (BW - n));
  endfunction

  function automatic logic [BW-1:0] rotr(input logic [BW-1:0] x, input int n);
    if (n == 0) return x;
    return (x >> n) | (x << (BW - n));
  endfunction

  logic [BW-1:0] rk  [ROUNDS];
  logic [BW-1:0] enc [ROUNDS+1];
  logic [BW-1:0] dec [ROUNDS+1];

  assign enc[0] = din;
  assign dec[0] = din;

  for (genvar i = 0; i < ROUNDS; i++) begin : g_round
    localparam int KS = (KROT * i) % BW;
    localparam logic [BW-1:0] RCI = BW'(RC * (i + 1));
    assign rk[i]    = rotl(key, KS) ^ RCI;
    assign enc[i+1] = rotl(enc[i] + rk[i], RS) ^ rk[i];
    // inverse walks the round keys backwards
    assign dec[i+1] = rotr(dec[i] ^ rk[ROUNDS-1-i], RS) - rk[ROUNDS-1-i];
  end

  assign dout = decrypt ? dec[ROUNDS] : enc[ROUNDS];
endmodule

// File: rtl/hs_ctrl.sv
// Sequencer and datapath registers; drives the shared cipher instance.
module hs_ctrl
  import hs_pkg::*;
#(
  parameter int BW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  hs_op_e        op,
  input  logic [BW-1:0] in_name,
  input  logic [PW-1:0] in_port,
  input  logic [BW-1:0] in_tag,
  input  logic [PW-1:0] mask,
  input  logic [BW-1:0] proc_key,
  input  logic [BW-1:0] alt_key,
  input  logic [PW-1:0] alt_port,
  input  logic          lk_ack,
  input  logic          lk_miss,
  input  logic [BW-1:0] lk_key,
  input  logic [BW-1:0] ciph_out,
  output logic [BW-1:0] ciph_in,
  output logic [BW-1:0] ciph_key,
  output logic          ciph_dec,
  output logic          lk_req,
  output logic [BW-1:0] lk_name,
  output logic          busy,
  output logic          done,
  output hs_status_e    status,
  output logic [BW-1:0] out_name,
  output logic [PW-1:0] out_port,
  output logic [BW-1:0] out_tag
);
  localparam int OWN = PW - 1;

  hs_state_e     state;
  hs_op_e        op_q;
  logic [BW-1:0] src_q, tag_in_q, nkey_q, ks_q, plain_q, sstar_q, mid_q;
  logic [PW-1:0] port_q, mask_q;
  logic          own_ok_q;

  assign busy    = (state != S_IDLE);
  assign lk_req  = (state == S_LOOK);
  assign lk_name = plain_q;

  always_comb begin
    ciph_dec = (state == S_NAME) && (op_q == OP_LOAD);
    ciph_key = (state == S_NAME) ? nkey_q : ks_q;
    unique case (state)
      S_NAME:  ciph_in = src_q;
      S_TAG1:  ciph_in = sstar_q;
      default: ciph_in = mid_q ^ BW'(port_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_LOAD;
      src_q    <= '0;
      tag_in_q <= '0;
      nkey_q   <= '0;
      ks_q     <= '0;
      plain_q  <= '0;
      sstar_q  <= '0;
      mid_q    <= '0;
      port_q   <= '0;
      mask_q   <= '0;
      own_ok_q <= 1'b0;
      done     <= 1'b0;
      status   <= ST_OK;
      out_name <= '0;
      out_port <= '0;
      out_tag  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q     <= op;
          src_q    <= in_name;
          tag_in_q <= in_tag;
          mask_q   <= (op == OP_REDUCE || op == OP_XCODE) ? mask : '1;
          port_q   <= (op == OP_REDUCE || op == OP_XCODE) ? (in_port & mask) : in_port;
          nkey_q   <= (op == OP_XCODE) ? alt_key : proc_key;
          own_ok_q <= in_port[OWN] & alt_port[OWN];
          state    <= S_NAME;
        end
        S_NAME: begin
          if (op_q == OP_XCODE && !own_ok_q) begin
            done     <= 1'b1;
            status   <= ST_PROT;
            out_name <= '0;
            out_port <= '0;
            out_tag  <= '0;
            state    <= S_IDLE;
          end else begin
            if (op_q == OP_LOAD) begin
              plain_q <= ciph_out;
              sstar_q <= src_q;
            end else begin
              plain_q <= src_q;
              sstar_q <= ciph_out;
            end
            state <= S_LOOK;
          end
        end
        S_LOOK: if (lk_ack) begin
          if (lk_miss) begin
            done     <= 1'b1;
            status   <= ST_ADDR;
            out_name <= '0;
            out_port <= '0;
            out_tag  <= '0;
            state    <= S_IDLE;
          end else begin
            ks_q  <= lk_key;
            state <= S_TAG1;
          end
        end
        S_TAG1: begin
          mid_q <= ciph_out;
          state <= S_TAG2;
        end
        S_TAG2: begin
          done  <= 1'b1;
          state <= S_IDLE;
          if (op_q == OP_LOAD) begin
            if (ciph_out == tag_in_q) begin
              status   <= ST_OK;
              out_name <= plain_q;
              out_port <= port_q;
              out_tag  <= '0;
            end else begin
              status   <= ST_PROT;
              out_name <= '0;
              out_port <= '0;
              out_tag  <= '0;
            end
          end else begin
            status   <= ST_OK;
            out_name <= sstar_q;
            out_port <= port_q;
            out_tag  <= ciph_out;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: result strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R8: request and name held until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    (lk_req && !lk_ack) |=> (lk_req && $stable(lk_name)));
  // R4, R5: failed operations leave no partial result
  a_r5_err_zero: assert property (@(posedge clk) disable iff (rst)
    (done && status != ST_OK) |-> (out_name == '0 && out_port == '0 && out_tag == '0));
  // R6: a sealed masked port never carries a bit the mask cleared
  a_r6_mask_kept: assert property (@(posedge clk) disable iff (rst)
    (done && status == ST_OK && op_q != OP_LOAD) |-> ((out_port & ~mask_q) == '0));
  // R7: refused transcode never reaches the key lookup
  a_r7_no_lookup: assert property (@(posedge clk) disable iff (rst)
    (lk_req && op_q == OP_XCODE) |-> own_ok_q);
  // R1: idle engine raises no request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst) !busy |-> !lk_req);
endmodule

// File: rtl/hs_engine.sv
module hs_engine #(
  parameter int BW     = 16,
  parameter int PW     = 8,
  parameter int ROUNDS = 4,
  parameter int ROT    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [BW-1:0] in_name,
  input  logic [PW-1:0] in_port,
  input  logic [BW-1:0] in_tag,
  input  logic [PW-1:0] mask,
  input  logic [BW-1:0] proc_key,
  input  logic [BW-1:0] alt_key,
  input  logic [PW-1:0] alt_port,
  output logic          lk_req,
  output logic [BW-1:0] lk_name,
  input  logic          lk_ack,
  input  logic          lk_miss,
  input  logic [BW-1:0] lk_key,
  output logic          busy,
  output logic          done,
  output logic [1:0]    status,
  output logic [BW-1:0] out_name,
  output logic [PW-1:0] out_port,
  output logic [BW-1:0] out_tag
);
  import hs_pkg::*;

  logic [BW-1:0] c_in, c_key, c_out;
  logic          c_dec;
  hs_status_e    st;

  hs_cipher #(.BW(BW), .ROUNDS(ROUNDS), .ROT(ROT)) u_cipher (
    .din(c_in), .key(c_key), .decrypt(c_dec), .dout(c_out)
  );

  hs_ctrl #(.BW(BW), .PW(PW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(hs_op_e'(op)),
    .in_name(in_name), .in_port(in_port), .in_tag(in_tag), .mask(mask),
    .proc_key(proc_key), .alt_key(alt_key), .alt_port(alt_port),
    .lk_ack(lk_ack), .lk_miss(lk_miss), .lk_key(lk_key),
    .ciph_out(c_out), .ciph_in(c_in), .ciph_key(c_key), .ciph_dec(c_dec),
    .lk_req(lk_req), .lk_name(lk_name), .busy(busy), .done(done),
    .status(st), .out_name(out_name), .out_port(out_port), .out_tag(out_tag)
  );

  assign status = st;
endmodule

// File: tb/tb_hs_engine.sv
module tb_hs_engine;
  localparam int NV = 10;
  localparam logic [15:0] PK = 16'h3C5A;
  localparam logic [15:0] AK = 16'h7E11;

  // op, name, port, mask, alt_port, corrupt tag, lookup wait
  localparam logic [45:0] VEC [NV] = '{
    {2'd1, 16'h1234, 8'h0F, 8'hFF, 8'h00, 1'b0, 3'd0},
    {2'd1, 16'h0ABC, 8'h83, 8'hFF, 8'h00, 1'b0, 3'd2},
    {2'd0, 16'h1234, 8'h0F, 8'hFF, 8'h00, 1'b0, 3'd1},
    {2'd0, 16'h0ABC, 8'h83, 8'hFF, 8'h00, 1'b1, 3'd0},
    {2'd2, 16'h2222, 8'hFF, 8'h35, 8'h00, 1'b0, 3'd0},
    {2'd3, 16'h4321, 8'h81, 8'hF1, 8'h80, 1'b0, 3'd1},
    {2'd3, 16'h4321, 8'h01, 8'hFF, 8'h80, 1'b0, 3'd0},
    {2'd1, 16'hF00D, 8'h11, 8'hFF, 8'h00, 1'b0, 3'd0},
    {2'd0, 16'hF123, 8'h22, 8'hFF, 8'h00, 1'b0, 3'd3},
    {2'd0, 16'h2222, 8'h35, 8'hFF, 8'h00, 1'b0, 3'd0}
  };

  function automatic logic [15:0] rl(input logic [15:0] x, input int n);
    if (n % 16 == 0) return x;
    return (x << (n % 16)) | (x >> (16 - n % 16));
  endfunction

  function automatic logic [15:0] enc(input logic [15:0] x, input logic [15:0] k);
    logic [15:0] v = x;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] r = rl(k, 4 * i) ^ 16'(32'h9E37 * (i + 1));
      v = rl(v + r, 5) ^ r;
    end
    return v;
  endfunction

  function automatic logic [15:0] key_of(input logic [15:0] n);
    return {n[7:0], n[15:8]} ^ 16'hC3A5;
  endfunction

  function automatic logic [15:0] tag_of(input logic [15:0] s, input logic [7:0] t, input logic [15:0] ks);
    return enc(enc(s, ks) ^ {8'h00, t}, ks);
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] in_name = '0, in_tag = '0, proc_key = PK, alt_key = AK;
  logic [7:0]  in_port = '0, mask = '0, alt_port = '0;
  logic        lk_req, lk_ack, lk_miss, busy, done;
  logic [15:0] lk_name, lk_key, out_name, out_tag;
  logic [7:0]  out_port;
  logic [1:0]  status;

  int wait_cyc = 0;
  int wcnt = 0;
  int req_cycles = 0;
  logic [15:0] seen_name = '0;
  int total = 0;
  int bad = 0;

  assign lk_ack  = lk_req && (wcnt >= wait_cyc);
  assign lk_miss = (lk_name[15:12] == 4'hF);
  assign lk_key  = key_of(lk_name);

  always @(posedge clk) begin
    if (lk_req && !lk_ack) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (lk_req) begin
      req_cycles <= req_cycles + 1;
      seen_name  <= lk_name;
    end
  end

  hs_engine dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .in_name(in_name),
    .in_port(in_port), .in_tag(in_tag), .mask(mask), .proc_key(proc_key),
    .alt_key(alt_key), .alt_port(alt_port), .lk_req(lk_req), .lk_name(lk_name),
    .lk_ack(lk_ack), .lk_miss(lk_miss), .lk_key(lk_key), .busy(busy),
    .done(done), .status(status), .out_name(out_name), .out_port(out_port),
    .out_tag(out_tag)
  );

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [15:0] nm, input logic [7:0] pt,
                     input logic [15:0] tg, input logic [7:0] mk, input logic [7:0] ap,
                     input int w, output int lat, output int reqs);
    int r0;
    @(negedge clk);
    wait_cyc = w;
    op = o; in_name = nm; in_port = pt; in_tag = tg; mask = mk; alt_port = ap;
    start = 1'b1;
    r0 = req_cycles;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog: actual no done expected done");
    end
    reqs = req_cycles - r0;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "lk_req", lk_req, 0);
    chk("R1", "status", status, 0);
    chk("R1", "result", {out_name, out_port, out_tag}, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] o = VEC[v][45:44];
      logic [15:0] nm = VEC[v][43:28];
      logic [7:0] pt = VEC[v][27:20];
      logic [7:0] mk = VEC[v][19:12];
      logic [7:0] ap = VEC[v][11:4];
      logic bd = VEC[v][3];
      int w = int'(VEC[v][2:0]);
      logic [15:0] sst = enc(nm, (o == 2'd3) ? AK : PK);
      logic [7:0] ep = (o >= 2'd2) ? (pt & mk) : pt;
      logic miss = (nm[15:12] == 4'hF);
      logic rej = (o == 2'd3) && !(pt[7] && ap[7]);
      logic [15:0] itag = (o == 2'd0) ? (tag_of(sst, pt, key_of(nm)) ^ {15'd0, bd}) : 16'h0;
      logic [15:0] iname = (o == 2'd0) ? sst : nm;
      logic [1:0] es;
      logic [39:0] eres;
      int elat, lat, reqs;
      string rq;
      rq = rej ? "R7" : miss ? "R5" : (o == 2'd0) ? (bd ? "R4" : "R3") :
           (o == 2'd1) ? "R2" : (o == 2'd2) ? "R6" : "R7";
      es = rej ? 2'd2 : miss ? 2'd1 : (o == 2'd0 && bd) ? 2'd2 : 2'd0;
      if (es != 2'd0) eres = '0;
      else if (o == 2'd0) eres = {nm, pt, 16'h0};
      else eres = {sst, ep, tag_of(sst, ep, key_of(nm))};
      elat = rej ? 2 : miss ? 3 + w : 5 + w;
      run(o, iname, pt, itag, mk, ap, w, lat, reqs);
      chk(rq, "status", status, es);
      chk(rq, "result", {out_name, out_port, out_tag}, eres);
      chk("R8", "latency", lat, elat);
      chk(rej ? "R7" : "R8", "lookup cycles", reqs, rej ? 0 : w + 1);
      if (!rej) chk(rq, "lookup name", seen_name, nm);
    end

    // R9: second start during an operation has no effect
    begin
      int lat = 0;
      int extra = 0;
      logic [15:0] sst = enc(16'h0777, PK);
      @(negedge clk);
      wait_cyc = 1;
      op = 2'd1; in_name = 16'h0777; in_port = 8'h42; mask = 8'hFF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat = 1;
      @(negedge clk);
      lat++;
      op = 2'd2; in_name = 16'h0999; in_port = 8'h0F; mask = 8'h01;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; lat++;
      while (!done && lat < 60) begin
        @(negedge clk);
        lat++;
      end
      chk("R9", "latency", lat, 6);
      chk("R9", "result", {out_name, out_port, out_tag},
          {sst, 8'h42, tag_of(sst, 8'h42, key_of(16'h0777))});
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R9", "extra done", extra, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule